// File: doc/BRIEF.md
# Masked-write GPIO bank controller

This block manages a large set of general-purpose pins, organised as banks of eight, behind a simple 32-bit register bus. For every bank, software picks pin by pin whether the pin belongs to the GPIO logic or to a special-function source elsewhere on the chip. A pin under GPIO control drives the level and direction held in the bank's registers. A pin left in special-function mode passes the special-function output and enable straight to the pad.

The direction and level registers each have a masked alias. Bits [15:8] of the write data pick which pins change, and bits [7:0] give their new values. Several drivers can therefore touch separate pins of one bank without a read-modify-write race. Pad levels reach a readable input register through a two-flop synchronizer.

Banks sit four to a group, at a 4-byte stride inside each group, and groups are 0x100 apart. The register kind is chosen by a field at a 0x800 stride above that.

Top module: `mwgpio_ctrl`

## Requirements
- R1: After reset, every configuration, direction and output-level bit is 0. All registers read as zero, and pad_out/pad_oe equal sf_out/sf_oe.
- R2: For each pin, a configuration bit of 1 drives pad_out and pad_oe from the bank's output-level and direction bits. A configuration bit of 0 drives them from sf_out and sf_oe.
- R3: A write to the masked output-level alias (kind 5) loads bit p from wdata[p] only where wdata[p+8] is 1. Every other output-level bit of that bank keeps its value.
- R4: A write to the masked direction alias (kind 4) follows the same rule for the direction bits. In the direction register, 1 means the pin drives and 0 means it is tristate.
- R5: Plain writes to configuration (kind 0), direction (kind 1) and output level (kind 2) load wdata[7:0]. Reading these registers returns the stored byte in bits [7:0], with zeros above.
- R6: The input register (kind 3) returns pad levels through two synchronizer flops. A read issued in the same cycle as a pad change, or one cycle later, returns the old level. A read issued two cycles later returns the new level.
- R7: Bank b is at byte address kind*0x800 + (b/4)*0x100 + (b%4)*4. Each of the 31 banks has its own storage.
- R8: Reads of the masked aliases return zero. Writes to the input register have no effect.
- R9: These addresses are unmapped: kind 6 or 7, a nonzero bit in [7:4] or [1:0], and the slot for bank 31 (group 7, slot 3). They read as zero and writes to them change nothing.
- R10: A read (bus_sel=1, bus_we=0) asserts bus_rvalid for exactly the following cycle, with the data. Writes never assert bus_rvalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 14 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| pad_in | input | 248 | Pad input levels, bank b at bits [8b+7:8b] |
| sf_out | input | 248 | Special-function output levels |
| sf_oe | input | 248 | Special-function output enables |
| pad_out | output | 248 | Pad output levels |
| pad_oe | output | 248 | Pad output enables |

## Verification
The hardest situations to reach are the ones where masked writes interleave with plain writes to the same bank while pins switch between special-function and GPIO control. In those cases the pad outputs show bits that are held back but never visible at the time of the write. To get there, the random phase concentrates writes of random 32-bit data on a few banks and covers all six register kinds. It mixes in unmapped addresses and then compares every pad output bit against a bench model. A directed sequence issues back-to-back reads right after a pad edge, so the exact synchronizer latency is exercised.

// File: rtl/mwgpio_pkg.sv
package mwgpio_pkg;
   localparam int PINS_PER_BANK   = 8;
   localparam int BANKS_PER_GROUP = 4;
   localparam int KIND_LSB        = 11;
   localparam int GROUP_LSB       = 8;
   localparam int BASE_ADDR_W     = 14;

   typedef enum logic [2:0] {
      REG_CFG  = 3'd0,
      REG_OE   = 3'd1,
      REG_OUT  = 3'd2,
      REG_IN   = 3'd3,
      REG_MOE  = 3'd4,
      REG_MOUT = 3'd5,
      REG_RSV6 = 3'd6,
      REG_RSV7 = 3'd7
   } reg_kind_e;

   function automatic logic [7:0] masked_merge(input logic [7:0] cur, input logic [15:0] wd);
      return (cur & ~wd[15:8]) | (wd[7:0] & wd[15:8]);
   endfunction
endpackage

// File: rtl/mwgpio_addr_dec.sv
module mwgpio_addr_dec
   import mwgpio_pkg::*;
#(
   parameter int ADDR_W    = 14,
   parameter int NUM_BANKS = 31,
   localparam int BANK_W   = 5
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [BANK_W-1:0] bank,
   output reg_kind_e         kind
);
   logic upper_zero;

   generate
      if (ADDR_W < BASE_ADDR_W) begin : g_bad_addr
         $error("mwgpio_addr_dec: ADDR_W must be at least 14");
      end
      if (ADDR_W > BASE_ADDR_W) begin : g_upper
         assign upper_zero = (addr[ADDR_W-1:BASE_ADDR_W] == '0);
      end else begin : g_no_upper
         assign upper_zero = 1'b1;
      end
   endgenerate

   always_comb begin
      kind = reg_kind_e'(addr[KIND_LSB +: 3]);
      bank = {addr[GROUP_LSB +: 3], addr[3:2]};
      hit  = upper_zero
          && (addr[1:0] == 2'b00)
          && (addr[7:4] == 4'h0)
          && (kind <= REG_MOUT)
          && (int'(bank) < NUM_BANKS);
   end
endmodule

// File: rtl/mwgpio_sync.sv
module mwgpio_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] chain [STAGES];

   generate
      if (STAGES < 1) begin : g_bad
         $error("mwgpio_sync: STAGES must be at least 1");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      chain[s] <= '0;
            else if (s == 0) chain[s] <= d;
            else             chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/mwgpio_bank.sv
module mwgpio_bank
   import mwgpio_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  reg_kind_e   kind,
   input  logic [15:0] wdata,
   output logic [7:0]  cfg_q,
   output logic [7:0]  oe_q,
   output logic [7:0]  out_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
         oe_q  <= '0;
         out_q <= '0;
      end else if (wr_en) begin
         case (kind)
            REG_CFG:  cfg_q <= wdata[7:0];
            REG_OE:   oe_q  <= wdata[7:0];
            REG_OUT:  out_q <= wdata[7:0];
            REG_MOE:  oe_q  <= masked_merge(oe_q, wdata);
            REG_MOUT: out_q <= masked_merge(out_q, wdata);
            default:  ;
         endcase
      end
   end

   assert_out_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && kind == REG_MOUT) |=> (((out_q ^ $past(out_q)) & ~$past(wdata[15:8])) == 8'h00));

   assert_oe_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && kind == REG_MOE) |=> (((oe_q ^ $past(oe_q)) & ~$past(wdata[15:8])) == 8'h00));

   assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(cfg_q) && $stable(oe_q) && $stable(out_q)));

   assert_in_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && kind == REG_IN) |=> ($stable(cfg_q) && $stable(oe_q) && $stable(out_q)));
endmodule

// File: rtl/mwgpio_ctrl.sv
module mwgpio_ctrl
   import mwgpio_pkg::*;
#(
   parameter int NUM_BANKS   = 31,
   parameter int ADDR_W      = 14,
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2,
   localparam int NPINS      = NUM_BANKS * PINS_PER_BANK,
   localparam int BANK_W     = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_rvalid,
   input  logic [NPINS-1:0]  pad_in,
   input  logic [NPINS-1:0]  sf_out,
   input  logic [NPINS-1:0]  sf_oe,
   output logic [NPINS-1:0]  pad_out,
   output logic [NPINS-1:0]  pad_oe
);
   generate
      if (NUM_BANKS < 1 || NUM_BANKS > 32) begin : g_bad_banks
         $error("mwgpio_ctrl: NUM_BANKS must be 1..32");
      end
      if (DATA_W < 16) begin : g_bad_data
         $error("mwgpio_ctrl: DATA_W must be at least 16");
      end
   endgenerate

   logic              dec_hit;
   logic [BANK_W-1:0] dec_bank;
   reg_kind_e         dec_kind;
   logic [NPINS-1:0]  pad_sync;
   logic [7:0]        cfg_q [NUM_BANKS];
   logic [7:0]        oe_q  [NUM_BANKS];
   logic [7:0]        out_q [NUM_BANKS];
   logic [7:0]        in_q  [NUM_BANKS];
   logic [7:0]        rd_byte;
   logic              rd_req;

   mwgpio_addr_dec #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) u_dec (
      .addr (bus_addr),
      .hit  (dec_hit),
      .bank (dec_bank),
      .kind (dec_kind)
   );

   mwgpio_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (pad_sync)
   );

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         logic       wr_b;
         logic [7:0] sel_gpio;

         assign wr_b = bus_sel && bus_we && dec_hit && (dec_bank == BANK_W'(b));

         mwgpio_bank u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (wr_b),
            .kind  (dec_kind),
            .wdata (bus_wdata[15:0]),
            .cfg_q (cfg_q[b]),
            .oe_q  (oe_q[b]),
            .out_q (out_q[b])
         );

         assign in_q[b]   = pad_sync[b*PINS_PER_BANK +: PINS_PER_BANK];
         assign sel_gpio  = cfg_q[b];
         assign pad_out[b*PINS_PER_BANK +: PINS_PER_BANK] =
            (sel_gpio & out_q[b]) | (~sel_gpio & sf_out[b*PINS_PER_BANK +: PINS_PER_BANK]);
         assign pad_oe[b*PINS_PER_BANK +: PINS_PER_BANK] =
            (sel_gpio & oe_q[b]) | (~sel_gpio & sf_oe[b*PINS_PER_BANK +: PINS_PER_BANK]);
      end
   endgenerate

   assign rd_req = bus_sel && !bus_we;

   always_comb begin
      rd_byte = 8'h00;
      if (dec_hit) begin
         case (dec_kind)
            REG_CFG: rd_byte = cfg_q[dec_bank];
            REG_OE:  rd_byte = oe_q[dec_bank];
            REG_OUT: rd_byte = out_q[dec_bank];
            REG_IN:  rd_byte = in_q[dec_bank];
            default: rd_byte = 8'h00;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rvalid <= 1'b0;
         bus_rdata  <= '0;
      end else begin
         bus_rvalid <= rd_req;
         if (rd_req) bus_rdata <= {{(DATA_W-8){1'b0}}, rd_byte};
      end
   end

   assert_rvalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> bus_rvalid);

   assert_no_rvalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> !bus_rvalid);

   assert_unmapped_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !dec_hit) |=> (bus_rdata == '0));

   assert_alias_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && dec_hit && (dec_kind == REG_MOE || dec_kind == REG_MOUT)) |=> (bus_rdata == '0));

   assert_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rvalid |-> (bus_rdata[DATA_W-1:8] == '0));
endmodule

// File: tb/mwgpio_ctrl_bench.sv
module mwgpio_ctrl_bench;
   localparam int NB = 31;
   localparam int NP = NB * 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0;
   logic          bus_we = 1'b0;
   logic [13:0]   bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          bus_rvalid;
   logic [NP-1:0] pad_in = '0;
   logic [NP-1:0] sf_out = '0;
   logic [NP-1:0] sf_oe = '0;
   logic [NP-1:0] pad_out;
   logic [NP-1:0] pad_oe;

   int  checks = 0;
   int  errors = 0;
   bit  done = 1'b0;

   logic [7:0] m_cfg [NB];
   logic [7:0] m_oe  [NB];
   logic [7:0] m_out [NB];

   always #5 clk = ~clk;

   mwgpio_ctrl u_mwgpio_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_rvalid(bus_rvalid), .pad_in(pad_in), .sf_out(sf_out), .sf_oe(sf_oe),
      .pad_out(pad_out), .pad_oe(pad_oe)
   );

   function automatic logic [13:0] addr_of(int b, int k);
      return 14'((k << 11) | ((b / 4) << 8) | ((b % 4) << 2));
   endfunction

   function automatic logic [7:0] merge(logic [7:0] cur, logic [31:0] d);
      return (cur & ~d[15:8]) | (d[7:0] & d[15:8]);
   endfunction

   function automatic logic [31:0] expect_read(int b, int k);
      case (k)
         0: return {24'h0, m_cfg[b]};
         1: return {24'h0, m_oe[b]};
         2: return {24'h0, m_out[b]};
         3: return {24'h0, pad_in[b*8 +: 8]};
         default: return 32'h0;
      endcase
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Called at a negedge; returns at the next negedge.
   task automatic bus_write(logic [13:0] a, logic [31:0] d);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
      chk("R10 no rvalid after write", {31'h0, bus_rvalid}, 32'h0);
   endtask

   task automatic bus_read(logic [13:0] a, output logic [31:0] d);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_sel = 1'b0;
      chk("R10 rvalid after read", {31'h0, bus_rvalid}, 32'h1);
      d = bus_rdata;
   endtask

   task automatic model_write(int b, int k, logic [31:0] d);
      case (k)
         0: m_cfg[b] = d[7:0];
         1: m_oe[b]  = d[7:0];
         2: m_out[b] = d[7:0];
         4: m_oe[b]  = merge(m_oe[b], d);
         5: m_out[b] = merge(m_out[b], d);
         default: ;
      endcase
   endtask

   task automatic check_pads(string req);
      for (int b = 0; b < NB; b++) begin
         logic [7:0] eo, ee;
         eo = (m_cfg[b] & m_out[b]) | (~m_cfg[b] & sf_out[b*8 +: 8]);
         ee = (m_cfg[b] & m_oe[b])  | (~m_cfg[b] & sf_oe[b*8 +: 8]);
         chk(req, {24'h0, pad_out[b*8 +: 8]}, {24'h0, eo});
         chk(req, {24'h0, pad_oe[b*8 +: 8]}, {24'h0, ee});
      end
   endtask

   task automatic randomize_vec(output logic [NP-1:0] v);
      for (int i = 0; i < NP; i += 32) v[i +: 8] = 8'($urandom());
      for (int i = 0; i < NP; i++) v[i] = 1'($urandom());
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      logic [31:0] rd;
      logic [7:0]  old_lvl;
      void'($urandom(32'd2024));
      for (int b = 0; b < NB; b++) begin m_cfg[b] = 0; m_oe[b] = 0; m_out[b] = 0; end
      randomize_vec(sf_out);
      randomize_vec(sf_oe);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check_pads("R1 reset pad passthrough");
      for (int b = 0; b < NB; b += 10) begin
         for (int k = 0; k < 3; k++) begin
            bus_read(addr_of(b, k), rd);
            chk("R1 reset register zero", rd, 32'h0);
         end
      end

      // R7: every bank has its own storage
      for (int b = 0; b < NB; b++) begin
         bus_write(addr_of(b, 1), 32'(b * 7 + 3));
         model_write(b, 1, 32'(b * 7 + 3));
      end
      for (int b = 0; b < NB; b++) begin
         bus_read(addr_of(b, 1), rd);
         chk("R7 bank address map", rd, expect_read(b, 1));
      end

      // R5: plain writes and upper-byte readback
      bus_write(addr_of(5, 2), 32'hFFFF_FFA5);
      model_write(5, 2, 32'hFFFF_FFA5);
      bus_read(addr_of(5, 2), rd);
      chk("R5 plain write readback", rd, 32'h0000_00A5);

      // R3: masked output write touches only enabled pins
      bus_write(addr_of(5, 5), 32'h0000_0F00);
      model_write(5, 5, 32'h0000_0F00);
      bus_read(addr_of(5, 2), rd);
      chk("R3 masked out clear low nibble", rd, 32'h0000_00A0);
      bus_write(addr_of(5, 5), 32'h0000_00FF);
      bus_read(addr_of(5, 2), rd);
      chk("R3 masked out empty mask keeps", rd, 32'h0000_00A0);

      // R4: masked direction write
      bus_write(addr_of(6, 4), 32'h0000_8181);
      model_write(6, 4, 32'h0000_8181);
      bus_read(addr_of(6, 1), rd);
      chk("R4 masked oe", rd, expect_read(6, 1));

      // R8: aliases read zero, input-register write ignored
      bus_read(addr_of(6, 4), rd);
      chk("R8 masked oe alias reads zero", rd, 32'h0);
      bus_read(addr_of(5, 5), rd);
      chk("R8 masked out alias reads zero", rd, 32'h0);
      bus_write(addr_of(6, 3), 32'h0000_FFFF);
      bus_read(addr_of(6, 1), rd);
      chk("R8 input write ignored", rd, expect_read(6, 1));

      // R9: unmapped addresses
      bus_write(addr_of(0, 0) | 14'h010, 32'h0000_FFFF);
      bus_write(addr_of(0, 6), 32'h0000_FFFF);
      bus_write(addr_of(0, 0) | 14'h001, 32'h0000_FFFF);
      bus_write(14'h070C, 32'h0000_FFFF);
      bus_read(addr_of(0, 0), rd);
      chk("R9 unmapped write no effect", rd, 32'h0);
      bus_read(14'h070C, rd);
      chk("R9 bank 31 slot reads zero", rd, 32'h0);
      bus_read(addr_of(0, 7), rd);
      chk("R9 kind 7 reads zero", rd, 32'h0);

      // R2: GPIO takes pins over
      bus_write(addr_of(5, 0), 32'h0000_00F0);
      model_write(5, 0, 32'h0000_00F0);
      bus_write(addr_of(6, 0), 32'h0000_00FF);
      model_write(6, 0, 32'h0000_00FF);
      check_pads("R2 pad mux");

      // R6: synchronizer latency on bank 9
      randomize_vec(pad_in);
      repeat (3) @(negedge clk);
      old_lvl = pad_in[72 +: 8];
      pad_in[72 +: 8] = ~old_lvl;
      bus_read(addr_of(9, 3), rd);
      chk("R6 same-cycle read old", rd, {24'h0, old_lvl});
      bus_read(addr_of(9, 3), rd);
      chk("R6 one-cycle read old", rd, {24'h0, old_lvl});
      bus_read(addr_of(9, 3), rd);
      chk("R6 two-cycle read new", rd, {24'h0, ~old_lvl});

      // Random phase: R3 R4 R5 R2 R9 against the model
      for (int n = 0; n < 1500; n++) begin
         int b, k;
         logic [13:0] a;
         logic [31:0] d;
         bit mapped;
         b = int'($urandom() % 4) * 8 + int'($urandom() % 2);
         if (b >= NB) b = 0;
         k = int'($urandom() % 6);
         a = addr_of(b, k);
         mapped = 1'b1;
         if ($urandom() % 10 == 0) begin
            mapped = 1'b0;
            case ($urandom() % 4)
               0: a = a | 14'h0020;
               1: a = addr_of(b, 6 + int'($urandom() % 2));
               2: a = a | 14'h0002;
               default: a = 14'((k << 11) | 14'h070C);
            endcase
         end
         d = $urandom();
         if ($urandom() % 2 == 0) begin
            bus_write(a, d);
            if (mapped) model_write(b, k, d);
         end else begin
            bus_read(a, rd);
            chk(mapped ? "R5 random read" : "R9 random unmapped read", rd,
                mapped ? expect_read(b, k) : 32'h0);
         end
         if (n % 50 == 49) begin
            check_pads("R2 random pad mux");
            randomize_vec(sf_out);
            randomize_vec(sf_oe);
            randomize_vec(pad_in);
            repeat (3) @(negedge clk);
            check_pads("R2 random sf change");
         end
      end

      done = 1'b1;
      finish_run();
   end
endmodule